// File: doc/BRIEF.md
# Coherent Byte-Read Timer Counter

This block is a 16-bit free-running timer counter that an 8-bit register bus sees as separate high and low byte registers. A counting step happens on each terminal tick of a power-of-two prescaler. The prescaler's 3-bit division select can be changed only while a separate unlock bit is set.

The counter can change between two byte reads. To keep the pair consistent, the first read of either byte captures all 16 bits into a holding buffer. Every counter byte read after that returns buffered data until the opposite byte has been read. A debug freeze input stops the counter and the prescaler, and it also holds the capture state. A read pair interrupted by a freeze therefore completes correctly afterwards.

Writing any value to either counter byte reloads the counter from a 16-bit initial-value register. That write also restarts the prescaler and drops any pending capture. A write to the control register also drops a pending capture.

Register map (3-bit address):

| Address | Contents |
|---|---|
| 0 | Control: bits [2:0] hold the prescale select; bit 3 is the count enable. |
| 1 | Counter high byte. |
| 2 | Counter low byte. |
| 3 | Initial value, high byte. |
| 4 | Initial value, low byte. |
| 5 | Unlock: bit 0 permits prescale writes. |

Top module: `coh_timer`

## Requirements
- R1: After reset, the counter high byte, counter low byte, control register and unlock register all read as 0x00.
- R2: The prescale select value p divides the count rate by 2^p. After a reload, the first increment lands 2^p enabled cycles later, and each later increment follows after another 2^p enabled cycles.
- R3: A control write while the unlock bit (address 5, bit 0) is 0 leaves the prescale select unchanged. While that bit is 1, the same write updates the select.
- R4: If the high byte (address 1) is read first, the read returns the live high byte and captures all 16 bits. The following low-byte read returns the captured low byte, even when a carry has occurred in between.
- R5: If the low byte (address 2) is read first, the read returns the live low byte and captures all 16 bits. The following high-byte read returns the captured high byte.
- R6: Reading the opposite byte releases the capture, so the next counter read returns live data and starts a new capture.
- R7: Any write to the control register (address 0) drops a pending capture.
- R8: A write of any data to address 1 or 2 loads the counter from the initial-value registers, restarts the prescaler and drops a pending capture.
- R9: While the freeze input is 1, the counter and prescaler hold their values. Counter reads during freeze change no capture state.
- R10: A count step from 0xFFFF loads the counter with the initial value.
- R11: The count enable (control bit 3) can be written regardless of the unlock bit. While it is 0, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| freeze | input | 1 | Debug freeze; holds the counter and the capture state |
| busAddr | input | 3 | Register address |
| busWrEn | input | 1 | Single-cycle write strobe |
| busRdEn | input | 1 | Single-cycle read strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, combinational for the addressed register |

## Verification
Register writes and count steps take effect at the clock edge that closes the strobe cycle. A reload therefore shows the initial value in the next cycle, and with prescale p the first increment is visible 2^p + 1 cycles after the reload write. Read data is combinational within the strobe cycle, and the capture it triggers governs the read in the following cycle. Every directed task places each access in a known cycle and samples the read data one time unit after the falling edge. The expected counter value is derived from the exact number of enabled, unfrozen edges since the reload.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W = 8;
  localparam int PS_W   = 3;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL    = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_HI  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT_LO  = 3'd2;
  localparam logic [ADDR_W-1:0] A_INIT_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_INIT_LO = 3'd4;
  localparam logic [ADDR_W-1:0] A_UNLOCK  = 3'd5;

  typedef enum logic [1:0] {
    COH_IDLE    = 2'd0,
    COH_WAIT_LO = 2'd1,
    COH_WAIT_HI = 2'd2
  } cohState_t;

  typedef struct packed {
    logic            reload;
    logic            run;
    logic [PS_W-1:0] psSel;
  } tmrStrobes_t;
endpackage

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W = 2 * BYTE_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobes_t      strb,
  input  logic [CNT_W-1:0] initVal,
  output logic [CNT_W-1:0] count
);
  localparam int DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divMask;
  logic             tick;

  always_comb begin
    for (int i = 0; i < DIV_W; i++) begin
      divMask[i] = (i < int'(strb.psSel));
    end
  end

  assign tick = (divCnt == divMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count  <= '0;
      divCnt <= '0;
    end else if (strb.reload) begin
      count  <= initVal;
      divCnt <= '0;
    end else if (strb.run) begin
      if (tick) begin
        divCnt <= '0;
        count  <= (count == '1) ? initVal : count + 1'b1;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  p_reload_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.reload |=> (count == $past(initVal)));

  p_hold_when_stopped_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.run && !strb.reload) |=> $stable(count));

  p_wrap_to_init_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && !strb.reload && tick && (count == '1)) |=> (count == $past(initVal)));

  p_no_step_without_tick_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && !strb.reload && !tick) |=> $stable(count));
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              freeze,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [BYTE_W-1:0] busWrData,
  output logic [BYTE_W-1:0] busRdData,
  input  logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  initVal,
  output tmrStrobes_t       strb
);
  localparam int CTRL_PAD = BYTE_W - PS_W - 1;

  logic [PS_W-1:0]   psReg;
  logic              cntEn;
  logic              unlock;
  logic [CNT_W-1:0]  cohBuf;
  cohState_t         cohState;

  logic wrCtrl, wrCnt, rdHi, rdLo, clearCoh;

  assign wrCtrl   = busWrEn && (busAddr == A_CTRL);
  assign wrCnt    = busWrEn && ((busAddr == A_CNT_HI) || (busAddr == A_CNT_LO));
  assign rdHi     = busRdEn && (busAddr == A_CNT_HI);
  assign rdLo     = busRdEn && (busAddr == A_CNT_LO);
  assign clearCoh = wrCtrl || wrCnt;

  assign strb.reload = wrCnt;
  assign strb.run    = cntEn && !freeze;
  assign strb.psSel  = psReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psReg   <= '0;
      cntEn   <= 1'b0;
      unlock  <= 1'b0;
      initVal <= '0;
    end else if (busWrEn) begin
      case (busAddr)
        A_CTRL: begin
          cntEn <= busWrData[PS_W];
          if (unlock) psReg <= busWrData[PS_W-1:0];
        end
        A_INIT_HI: initVal[CNT_W-1:BYTE_W] <= busWrData;
        A_INIT_LO: initVal[BYTE_W-1:0]     <= busWrData;
        A_UNLOCK:  unlock <= busWrData[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cohState <= COH_IDLE;
      cohBuf   <= '0;
    end else if (clearCoh) begin
      cohState <= COH_IDLE;
    end else if (!freeze) begin
      case (cohState)
        COH_IDLE: begin
          if (rdHi) begin
            cohState <= COH_WAIT_LO;
            cohBuf   <= count;
          end else if (rdLo) begin
            cohState <= COH_WAIT_HI;
            cohBuf   <= count;
          end
        end
        COH_WAIT_LO: if (rdLo) cohState <= COH_IDLE;
        COH_WAIT_HI: if (rdHi) cohState <= COH_IDLE;
        default:     cohState <= COH_IDLE;
      endcase
    end
  end

  logic [CNT_W-1:0] cntView;
  assign cntView = (cohState == COH_IDLE) ? count : cohBuf;

  always_comb begin
    case (busAddr)
      A_CTRL:    busRdData = {{CTRL_PAD{1'b0}}, cntEn, psReg};
      A_CNT_HI:  busRdData = cntView[CNT_W-1:BYTE_W];
      A_CNT_LO:  busRdData = cntView[BYTE_W-1:0];
      A_INIT_HI: busRdData = initVal[CNT_W-1:BYTE_W];
      A_INIT_LO: busRdData = initVal[BYTE_W-1:0];
      A_UNLOCK:  busRdData = {{(BYTE_W-1){1'b0}}, unlock};
      default:   busRdData = '0;
    endcase
  end

  p_ps_locked_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && (busAddr == A_CTRL) && !unlock) |=> $stable(psReg));

  p_hi_capture_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((cohState == COH_IDLE) && rdHi && !freeze && !busWrEn)
      |=> ((cohState == COH_WAIT_LO) && (cohBuf == $past(count))));

  p_lo_capture_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((cohState == COH_IDLE) && rdLo && !freeze && !busWrEn)
      |=> ((cohState == COH_WAIT_HI) && (cohBuf == $past(count))));

  p_freeze_coh_r9: assert property (@(posedge clk) disable iff (!rstN)
    (freeze && !busWrEn) |=> ($stable(cohState) && $stable(cohBuf)));

  p_write_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && ((busAddr == A_CTRL) || (busAddr == A_CNT_HI) || (busAddr == A_CNT_LO)))
      |=> (cohState == COH_IDLE));
endmodule

// File: rtl/coh_timer.sv
module coh_timer
  import tmr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        freeze,
  input  logic [2:0]  busAddr,
  input  logic        busWrEn,
  input  logic        busRdEn,
  input  logic [7:0]  busWrData,
  output logic [7:0]  busRdData
);
  localparam int CNT_W = 2 * BYTE_W;

  tmrStrobes_t      strb;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] initVal;

  tmr_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .freeze    (freeze),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busRdEn   (busRdEn),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .count     (count),
    .initVal   (initVal),
    .strb      (strb)
  );

  tmr_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .initVal (initVal),
    .count   (count)
  );
endmodule

// File: tb/coh_timer_tb.sv
module coh_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] CTRL = 3'd0, CNTH = 3'd1, CNTL = 3'd2,
                         INTH = 3'd3, INTL = 3'd4, UNLK = 3'd5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       freeze = 1'b0;
  logic [2:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic       busRdEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  coh_timer u_dut (
    .clk(clk), .rstN(rstN), .freeze(freeze), .busAddr(busAddr),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busWrData(busWrData),
    .busRdData(busRdData)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic rdChk(input logic [2:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #1 check(req, busRdData, exp);
    @(posedge clk); #1;
    busRdEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic setFreeze(input logic v);
    @(negedge clk);
    freeze = v;
    @(posedge clk); #1;
  endtask

  task automatic setupRun(input logic [7:0] ctrlVal, input logic [15:0] init);
    wr(UNLK, 8'h01);
    wr(CTRL, ctrlVal);
    wr(INTH, init[15:8]);
    wr(INTL, init[7:0]);
  endtask

  task automatic tReset();
    rdChk(CNTH, 8'h00, "R1 cnt hi");
    rdChk(CNTL, 8'h00, "R1 cnt lo");
    rdChk(CTRL, 8'h00, "R1 ctrl");
    rdChk(UNLK, 8'h00, "R1 unlock");
  endtask

  task automatic tHiFirst();
    setupRun(8'h08, 16'h12FF);
    wr(CNTH, 8'hAA);
    rdChk(CNTH, 8'h12, "R4 hi first");
    rdChk(CNTL, 8'hFF, "R4 lo buffered across carry");
    rdChk(CNTH, 8'h13, "R6 fresh hi after release");
    rdChk(CNTL, 8'h01, "R6 new capture lo");
  endtask

  task automatic tLoFirst();
    setupRun(8'h08, 16'h12FF);
    wr(CNTL, 8'h5C);
    rdChk(CNTL, 8'hFF, "R5 lo first");
    rdChk(CNTH, 8'h12, "R5 hi buffered across carry");
  endtask

  task automatic tWriteMidRead();
    setupRun(8'h08, 16'h12FF);
    wr(CNTH, 8'h00);
    rdChk(CNTH, 8'h12, "R8 first half");
    wr(CNTL, 8'h77);
    idle(2);
    rdChk(CNTH, 8'h13, "R8 reload clears capture");
    rdChk(CNTL, 8'h01, "R8 new capture lo");
  endtask

  task automatic tCtrlClears();
    setupRun(8'h08, 16'h12FF);
    wr(CNTH, 8'h00);
    rdChk(CNTH, 8'h12, "R7 first half");
    wr(CTRL, 8'h08);
    idle(2);
    rdChk(CNTH, 8'h13, "R7 ctrl write clears capture");
    rdChk(CNTL, 8'h03, "R7 new capture lo");
  endtask

  task automatic tFreeze();
    setupRun(8'h08, 16'h12FF);
    wr(CNTH, 8'h00);
    rdChk(CNTH, 8'h12, "R9 first half");
    setFreeze(1'b1);
    rdChk(CNTL, 8'hFF, "R9 lo during freeze buffered");
    rdChk(CNTH, 8'h12, "R9 state held during freeze");
    setFreeze(1'b0);
    rdChk(CNTL, 8'hFF, "R9 pair completes after freeze");
    rdChk(CNTH, 8'h13, "R9 fresh hi");
    rdChk(CNTL, 8'h02, "R9 counter stopped while frozen");
  endtask

  task automatic tPrescale();
    setupRun(8'h0A, 16'h0010);
    wr(CNTH, 8'h00);
    idle(3);
    rdChk(CNTL, 8'h10, "R2 no step before 4 cycles");
    rdChk(CNTH, 8'h00, "R2 hi");
    idle(2);
    rdChk(CNTL, 8'h11, "R2 one step after first period");
    rdChk(CNTH, 8'h00, "R2 hi");
    rdChk(CNTL, 8'h12, "R2 second step");
    rdChk(CNTH, 8'h00, "R2 hi");
  endtask

  task automatic tProtect();
    wr(UNLK, 8'h01);
    wr(CTRL, 8'h0A);
    wr(UNLK, 8'h00);
    wr(CTRL, 8'h03);
    rdChk(CTRL, 8'h02, "R3 ps locked, R11 enable still written");
    wr(UNLK, 8'h01);
    wr(CTRL, 8'h0B);
    rdChk(CTRL, 8'h0B, "R3 ps written when unlocked");
  endtask

  task automatic tWrap();
    setupRun(8'h00, 16'hFFFE);
    wr(CNTH, 8'h00);
    idle(3);
    rdChk(CNTL, 8'hFE, "R11 disabled counter holds");
    rdChk(CNTH, 8'hFF, "R11 hi");
    wr(INTH, 8'h00);
    wr(INTL, 8'h05);
    wr(CTRL, 8'h08);
    idle(2);
    rdChk(CNTL, 8'h05, "R10 wrap to init lo");
    rdChk(CNTH, 8'h00, "R10 wrap to init hi");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    tReset();
    tHiFirst();
    tLoFirst();
    tWriteMidRead();
    tCtrlClears();
    tFreeze();
    tPrescale();
    tProtect();
    tWrap();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule